// File: doc/BRIEF.md
# IDE Programmed-I/O Strobe Timing Generator

This block drives the active-low read and write strobes for programmed-I/O transfers on a two-drive IDE channel. A requester presents an address, a direction, a drive number and write data on a valid/acknowledge port. When the address belongs to the implemented channel, the block lowers the matching strobe. It holds the strobe low until the IORDY sample point and for as long as IORDY stays low after it. It then releases the strobe and acknowledges the request. Before the next strobe it inserts a programmable recovery gap.

Timing comes from two small register fields: a sample-point code and a recovery code. A shared set of fields covers the channel, and a second set applies only to drive 1 when a selection bit is set. Addresses of the absent second channel are acknowledged at once with zero data and no strobe. Decode of the implemented channel needs both a channel decode-enable bit and an external I/O-space enable. A third register keeps its written value but does not affect timing.

Top module: `pio_strobe_gen`

## Requirements
- R1: During and after reset both strobes are high, and the registers at offsets 40h, 42h and 44h read 0000h.
- R2: The strobe stays low for exactly the sample-point count when IORDY is high. Sample code 00 gives 5 clocks, 01 gives 4, 10 gives 3, and the reserved code 11 also gives 3.
- R3: After a strobe rises, the next strobe falls no sooner than the recovery count: code 00 gives 4 clocks, 01 gives 3, 10 gives 2, 11 gives 1. A request that arrives back to back waits exactly that long and is not acknowledged earlier.
- R4: Register 40h holds decode enable in bit 15, the drive-1 selection bit in bit 14, the sample code in bits 13:12 and the recovery code in bits 9:8. Register 44h holds the drive-1 sample code in bits 3:2 and the drive-1 recovery code in bits 1:0. The 44h fields are used only for drive-1 accesses while bit 14 of 40h is 1; all other accesses use the 40h fields.
- R5: If IORDY is low at the sample point, the strobe stays low and IORDY is sampled every clock. The strobe rises on the clock after the first clock on which IORDY is high.
- R6: A read lowers only the read strobe and returns the data bus value on the acknowledging cycle. A write lowers only the write strobe, drives the request's write data throughout, and returns zero. Both strobes are never low at once.
- R7: Accesses to 170h–177h and to 376h are acknowledged in their first cycle with zero data and no strobe.
- R8: Addresses 1F0h–1F7h and 3F6h produce a strobe only while io_space_en is 1 and bit 15 of register 40h is 1. Otherwise they behave as in R7.
- R9: Register 42h keeps all 16 written bits but does not affect timing. Register 44h is 8 bits wide, and bits 7:4 are plain storage that reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request pending |
| req_addr | input | 16 | I/O address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_drive | input | 1 | Target drive number |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | Access complete (combinational, one cycle) |
| rsp_rdata | output | 16 | Read data, valid with req_ack |
| io_space_en | input | 1 | External I/O-space enable |
| iordy | input | 1 | Drive ready |
| dbus_in | input | 16 | Data bus from the drive |
| dbus_out | output | 16 | Data bus to the drive |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 8 | Register offset |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |

## Verification
Two functions can fall in the same cycle: the end of a recovery window and the start of a waiting request. The recovery counter reaching zero and the new strobe asserting share one edge. This is provoked by issuing a second request right after the first one is acknowledged, for every pairing of sample and recovery code, for both drives, and with drive-1 selection on and off. The result is judged by the measured number of high clocks between the two strobes, which must equal the recovery count of the selected fields. The strobe width and the read data are checked in the same runs.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;
  localparam int REG_W  = 16;
  localparam int D1_W   = 8;
  localparam int CNT_W  = 3;
  localparam logic [7:0] OFF_PRI = 8'h40;
  localparam logic [7:0] OFF_SEC = 8'h42;
  localparam logic [7:0] OFF_D1  = 8'h44;
  localparam int BIT_DEC_EN = 15;
  localparam int BIT_D1_SEL = 14;

  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_RECOVER} st_e;
  typedef enum logic [1:0] {TGT_NONE, TGT_PRI, TGT_ZERO} tgt_e;

  typedef struct packed {
    logic [1:0] smp;
    logic [1:0] rec;
  } timing_t;

  function automatic logic [CNT_W-1:0] smp_clocks(input logic [1:0] code);
    case (code)
      2'b00:   smp_clocks = 3'd5;
      2'b01:   smp_clocks = 3'd4;
      default: smp_clocks = 3'd3;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] rec_clocks(input logic [1:0] code);
    rec_clocks = 3'd4 - {1'b0, code};
  endfunction
endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
  import pio_strobe_pkg::*;
#(
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output timing_t           pri_tim,
  output timing_t           d1_tim,
  output logic              d1_sel,
  output logic              dec_en
);
  logic [REG_W-1:0] pri_q, pri_d, sec_q, sec_d;
  logic [D1_W-1:0]  d1_q, d1_d;
  logic             pri_en, sec_en, d1_en;

  always_comb begin
    pri_en = cfg_we && (cfg_addr == CFG_AW'(OFF_PRI));
    sec_en = cfg_we && (cfg_addr == CFG_AW'(OFF_SEC));
    d1_en  = cfg_we && (cfg_addr == CFG_AW'(OFF_D1));
    pri_d  = pri_en ? cfg_wdata : pri_q;
    sec_d  = sec_en ? cfg_wdata : sec_q;
    d1_d   = d1_en  ? cfg_wdata[D1_W-1:0] : d1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      sec_q <= '0;
      d1_q  <= '0;
    end else begin
      pri_q <= pri_d;
      sec_q <= sec_d;
      d1_q  <= d1_d;
    end
  end

  always_comb begin
    if (cfg_addr == CFG_AW'(OFF_PRI))     cfg_rdata = pri_q;
    else if (cfg_addr == CFG_AW'(OFF_SEC)) cfg_rdata = sec_q;
    else if (cfg_addr == CFG_AW'(OFF_D1))  cfg_rdata = {{(REG_W-D1_W){1'b0}}, d1_q};
    else                                   cfg_rdata = '0;
  end

  assign dec_en      = pri_q[BIT_DEC_EN];
  assign d1_sel      = pri_q[BIT_D1_SEL];
  assign pri_tim.smp = pri_q[13:12];
  assign pri_tim.rec = pri_q[9:8];
  assign d1_tim.smp  = d1_q[3:2];
  assign d1_tim.rec  = d1_q[1:0];
endmodule

// File: rtl/pio_addr_decode.sv
module pio_addr_decode
  import pio_strobe_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_space_en,
  input  logic              dec_en,
  output tgt_e              tgt
);
  localparam logic [ADDR_W-1:0] PRI_CMD  = ADDR_W'(16'h01F0);
  localparam logic [ADDR_W-1:0] PRI_CTL  = ADDR_W'(16'h03F6);
  localparam logic [ADDR_W-1:0] SEC_CMD  = ADDR_W'(16'h0170);
  localparam logic [ADDR_W-1:0] SEC_CTL  = ADDR_W'(16'h0376);

  logic pri_hit, sec_hit;

  always_comb begin
    pri_hit = (addr[ADDR_W-1:3] == PRI_CMD[ADDR_W-1:3]) || (addr == PRI_CTL);
    sec_hit = (addr[ADDR_W-1:3] == SEC_CMD[ADDR_W-1:3]) || (addr == SEC_CTL);
    if (pri_hit && io_space_en && dec_en) tgt = TGT_PRI;
    else if (sec_hit)                     tgt = TGT_ZERO;
    else                                  tgt = TGT_NONE;
  end
endmodule

// File: rtl/pio_strobe_fsm.sv
module pio_strobe_fsm
  import pio_strobe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_drive,
  input  logic [DATA_W-1:0] req_wdata,
  input  tgt_e              tgt,
  input  timing_t           pri_tim,
  input  timing_t           d1_tim,
  input  logic              d1_sel,
  input  logic              iordy,
  input  logic [DATA_W-1:0] dbus_in,
  output logic              req_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] dbus_out,
  output logic              rd_strobe_n,
  output logic              wr_strobe_n
);
  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       rec_q, rec_d;
  logic             wr_q, wr_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  timing_t          sel;
  logic             can_start, start, done, zero_ack;

  always_comb begin
    sel       = (req_drive && d1_sel) ? d1_tim : pri_tim;
    can_start = (st_q == ST_IDLE) || ((st_q == ST_RECOVER) && (cnt_q == '0));
    start     = can_start && req_valid && (tgt == TGT_PRI);
    zero_ack  = can_start && req_valid && (tgt != TGT_PRI);
    done      = (st_q == ST_STROBE) && (cnt_q == '0) && iordy;
    req_ack   = done || zero_ack;
    rsp_rdata = (done && !wr_q) ? dbus_in : '0;
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    rec_d  = rec_q;
    wr_d   = wr_q;
    dout_d = dout_q;
    if (start) begin
      st_d   = ST_STROBE;
      cnt_d  = smp_clocks(sel.smp) - 3'd1;
      rec_d  = sel.rec;
      wr_d   = req_write;
      dout_d = req_wdata;
    end else begin
      case (st_q)
        ST_STROBE: begin
          if (cnt_q != '0) begin
            cnt_d = cnt_q - 3'd1;
          end else if (iordy) begin
            st_d  = ST_RECOVER;
            cnt_d = rec_clocks(rec_q) - 3'd1;
          end
        end
        ST_RECOVER: begin
          if (cnt_q != '0) cnt_d = cnt_q - 3'd1;
          else             st_d  = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rec_q  <= '0;
      wr_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rec_q  <= rec_d;
      wr_q   <= wr_d;
      dout_q <= dout_d;
    end
  end

  assign rd_strobe_n = !((st_q == ST_STROBE) && !wr_q);
  assign wr_strobe_n = !((st_q == ST_STROBE) && wr_q);
  assign dbus_out    = dout_q;
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_strobe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_drive,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              io_space_en,
  input  logic              iordy,
  input  logic [DATA_W-1:0] dbus_in,
  output logic [DATA_W-1:0] dbus_out,
  output logic              rd_strobe_n,
  output logic              wr_strobe_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata
);
  timing_t pri_tim, d1_tim;
  logic    d1_sel, dec_en;
  tgt_e    tgt;

  pio_timing_regs #(.CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pri_tim(pri_tim),
    .d1_tim(d1_tim), .d1_sel(d1_sel), .dec_en(dec_en)
  );

  pio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .io_space_en(io_space_en), .dec_en(dec_en), .tgt(tgt)
  );

  pio_strobe_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_drive(req_drive), .req_wdata(req_wdata), .tgt(tgt),
    .pri_tim(pri_tim), .d1_tim(d1_tim), .d1_sel(d1_sel), .iordy(iordy),
    .dbus_in(dbus_in), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
    .dbus_out(dbus_out), .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n)
  );
endmodule

// File: rtl/pio_strobe_chk.sv
module pio_strobe_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ack,
  input logic [ADDR_W-1:0] req_addr,
  input logic              io_space_en,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              iordy,
  input logic              rd_strobe_n,
  input logic              wr_strobe_n
);
  logic s_lo;
  logic sec_addr;
  assign s_lo     = !rd_strobe_n || !wr_strobe_n;
  assign sec_addr = (req_addr[ADDR_W-1:3] == 13'h002E) || (req_addr == ADDR_W'(16'h0376));

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_HIGH: assert (rd_strobe_n && wr_strobe_n); // R1
    end
  end

  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_lo) |=> s_lo ##1 s_lo); // R2

  AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (s_lo && !iordy) |=> s_lo); // R5

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_strobe_n && !wr_strobe_n)); // R6

  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack && s_lo) |=> !s_lo); // R6

  AST_SEC_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack && sec_addr) |-> (!s_lo && rsp_rdata == '0)); // R7

  AST_NO_IO_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_space_en && !s_lo) |=> !s_lo); // R8
endmodule

bind pio_strobe_gen pio_strobe_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .req_addr(req_addr),
  .io_space_en(io_space_en), .rsp_rdata(rsp_rdata), .iordy(iordy),
  .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n)
);

// File: tb/pio_strobe_gen_bench.sv
`timescale 1ns/1ps
module pio_strobe_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_drive = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        req_ack;
  logic [15:0] rsp_rdata;
  logic        io_space_en = 1'b1;
  logic        iordy = 1'b1;
  logic [15:0] dbus_in = '0;
  logic [15:0] dbus_out;
  logic        rd_strobe_n, wr_strobe_n;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;

  int n_chk = 0, n_fail = 0;
  int lo_run = 0, hi_run = 0, last_width = 0, prev_width = 0, last_gap = 0;
  int n_rd = 0, n_wr = 0, both_low = 0, wr_bad = 0;
  logic lo_prev = 1'b0;
  logic [15:0] exp_wdata = '0;

  always #2.5 clk = ~clk;

  pio_strobe_gen u_pio_strobe_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_drive(req_drive), .req_wdata(req_wdata),
    .req_ack(req_ack), .rsp_rdata(rsp_rdata), .io_space_en(io_space_en),
    .iordy(iordy), .dbus_in(dbus_in), .dbus_out(dbus_out),
    .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  always @(negedge clk) begin
    logic lo;
    lo = !rd_strobe_n || !wr_strobe_n;
    if (lo) begin
      if (!lo_prev) begin
        last_gap = hi_run;
        if (!rd_strobe_n) n_rd++; else n_wr++;
      end
      lo_run++;
      hi_run = 0;
      if (!rd_strobe_n && !wr_strobe_n) both_low++;
      if (!wr_strobe_n && dbus_out != exp_wdata) wr_bad++;
    end else begin
      if (lo_prev) begin
        prev_width = last_width;
        last_width = lo_run;
      end
      lo_run = 0;
      hi_run++;
    end
    lo_prev = lo;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int smp_n(input int c);
    return (c == 0) ? 5 : (c == 1) ? 4 : 3;
  endfunction

  function automatic int rec_n(input int c);
    return 4 - c;
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  // hold_at > 0: IORDY low until the strobe has been low hold_at cycles
  task automatic do_io(input logic [15:0] a, input logic w, input logic drv,
                       input logic [15:0] wd, input logic [15:0] bus,
                       input int hold_at, output logic [15:0] rd);
    int lc = 0;
    int guard = 0;
    @(negedge clk);
    req_addr = a; req_write = w; req_drive = drv; req_wdata = wd;
    exp_wdata = wd; dbus_in = bus; req_valid = 1'b1;
    iordy = (hold_at == 0);
    #1;
    while (!req_ack && guard < 200) begin
      @(negedge clk);
      if (!rd_strobe_n || !wr_strobe_n) lc++;
      if (hold_at > 0 && lc >= hold_at) iordy = 1'b1;
      #1;
      guard++;
    end
    if (!req_ack) begin
      n_fail++; n_chk++;
      $display("FAIL R3 no acknowledge actual=0 expected=1");
    end
    rd = rsp_rdata;
    @(posedge clk); #1;
    req_valid = 1'b0;
    iordy = 1'b1;
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v, ra, rb;
    int rd0, wr0;
    repeat (3) @(negedge clk);
    check(rd_strobe_n && wr_strobe_n, "R1 strobes in reset", {rd_strobe_n, wr_strobe_n}, 3);
    rst_n = 1'b1;
    cfg_read(8'h40, v); check(v == 16'h0000, "R1 reset 40h", v, 0);
    cfg_read(8'h42, v); check(v == 16'h0000, "R1 reset 42h", v, 0);
    cfg_read(8'h44, v); check(v == 16'h0000, "R1 reset 44h", v, 0);
    check(rd_strobe_n && wr_strobe_n, "R1 strobes idle", {rd_strobe_n, wr_strobe_n}, 3);

    // R9 register storage
    cfg_write(8'h42, 16'hBEEF);
    cfg_read(8'h42, v); check(v == 16'hBEEF, "R9 42h readback", v, 16'hBEEF);
    cfg_write(8'h44, 16'hFFFF);
    cfg_read(8'h44, v); check(v == 16'h00FF, "R9 44h width", v, 16'h00FF);
    cfg_write(8'h40, 16'hC000);
    cfg_read(8'h40, v); check(v == 16'hC000, "R4 40h readback", v, 16'hC000);

    // R2 R3 R4 sweep over codes, drive and drive-1 selection
    for (int en = 0; en < 2; en++) begin
      for (int pc = 0; pc < 4; pc++) begin
        for (int pr = 0; pr < 4; pr++) begin
          int dc, dr;
          dc = 3 - pc;
          dr = (pr + 1) % 4;
          cfg_write(8'h40, {1'b1, en[0], pc[1:0], 2'b00, pr[1:0], 8'h00});
          cfg_write(8'h44, {8'h00, 4'hA, dc[1:0], dr[1:0]});
          for (int dv = 0; dv < 2; dv++) begin
            int en_n, en_r;
            bit use_d1;
            use_d1 = (dv == 1) && (en == 1);
            en_n = use_d1 ? smp_n(dc) : smp_n(pc);
            en_r = use_d1 ? rec_n(dr) : rec_n(pr);
            do_io(16'h01F0 + 16'(pc), 1'b0, dv[0], 16'h0, 16'h1234 + 16'(pr), 0, ra);
            do_io(16'h01F7, 1'b0, dv[0], 16'h0, 16'h5A00 + 16'(dc), 0, rb);
            @(negedge clk); #1;
            check(prev_width == en_n, "R2 R4 strobe width", prev_width, en_n);
            check(last_gap == en_r, "R3 R4 recovery gap", last_gap, en_r);
            check(last_width == en_n, "R2 second width", last_width, en_n);
            check(ra == 16'h1234 + 16'(pr), "R6 read data", ra, 16'h1234 + 16'(pr));
          end
        end
      end
    end

    // R5 IORDY held low past the sample point (sample code 00 = 5 clocks)
    cfg_write(8'h40, 16'h8000);
    do_io(16'h01F2, 1'b0, 1'b0, 16'h0, 16'h0F0F, 6, ra);
    @(negedge clk); #1;
    check(last_width == 6, "R5 one wait clock", last_width, 6);
    check(ra == 16'h0F0F, "R5 data after wait", ra, 16'h0F0F);
    do_io(16'h01F2, 1'b0, 1'b0, 16'h0, 16'h0F0F, 9, ra);
    @(negedge clk); #1;
    check(last_width == 9, "R5 four wait clocks", last_width, 9);

    // R6 write uses write strobe and drives data
    rd0 = n_rd; wr0 = n_wr; wr_bad = 0;
    do_io(16'h01F0, 1'b1, 1'b0, 16'hA55A, 16'hFFFF, 0, ra);
    @(negedge clk); #1;
    check(n_wr == wr0 + 1 && n_rd == rd0, "R6 write strobe only", n_wr - wr0, 1);
    check(wr_bad == 0, "R6 write data driven", wr_bad, 0);
    check(ra == 16'h0000, "R6 write returns zero", ra, 0);
    check(both_low == 0, "R6 single strobe", both_low, 0);

    // R7 absent channel
    rd0 = n_rd; wr0 = n_wr;
    do_io(16'h0170, 1'b0, 1'b0, 16'h0, 16'hFFFF, 0, ra);
    check(ra == 16'h0000, "R7 170h zero", ra, 0);
    do_io(16'h0177, 1'b0, 1'b1, 16'h0, 16'hFFFF, 0, ra);
    check(ra == 16'h0000, "R7 177h zero", ra, 0);
    do_io(16'h0376, 1'b1, 1'b0, 16'h1111, 16'hFFFF, 0, ra);
    check(ra == 16'h0000, "R7 376h zero", ra, 0);
    @(negedge clk); #1;
    check(n_rd == rd0 && n_wr == wr0, "R7 no strobe", n_rd + n_wr - rd0 - wr0, 0);

    // R8 decode gating
    io_space_en = 1'b0;
    do_io(16'h01F7, 1'b0, 1'b0, 16'h0, 16'hFFFF, 0, ra);
    check(ra == 16'h0000, "R8 io space off", ra, 0);
    io_space_en = 1'b1;
    cfg_write(8'h40, 16'h0000);
    do_io(16'h03F6, 1'b0, 1'b0, 16'h0, 16'hFFFF, 0, ra);
    check(ra == 16'h0000, "R8 decode off", ra, 0);
    @(negedge clk); #1;
    check(n_rd == rd0 && n_wr == wr0, "R8 no strobe when gated", n_rd + n_wr - rd0 - wr0, 0);
    cfg_write(8'h40, 16'h8000);
    do_io(16'h03F6, 1'b0, 1'b0, 16'h0, 16'hC3C3, 0, ra);
    @(negedge clk); #1;
    check(ra == 16'hC3C3 && n_rd == rd0 + 1, "R8 decode on", ra, 16'hC3C3);

    // R9 42h has no effect on timing
    cfg_write(8'h42, 16'hFFFF);
    cfg_write(8'h40, 16'hA000);
    do_io(16'h01F1, 1'b0, 1'b0, 16'h0, 16'h7777, 0, ra);
    @(negedge clk); #1;
    check(last_width == 3, "R9 42h no timing effect", last_width, 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule